// File: doc/BRIEF.md
# Channel Fault Protection Manager

This block handles overload and over-temperature protection for a bank of low-side switch channels and keeps sticky diagnosis flags for each of them. For every channel it receives a gate request, an overload-detect level, an over-temperature level whose hysteresis is handled outside, and the outputs of the open-load and short-to-ground comparators. It returns a per-channel fault-off signal that the gate driver combines with the request. It also returns the protection flags, the latched diagnosis flags, and a packed diagnosis word with two bits per channel that a serial interface shifts out.

Each channel has two mode bits. On overload it either keeps conducting and only reports after a long delay, or it switches off after a shorter delay. On over-temperature it either restarts by itself once the temperature signal clears, or it stays off until software clears the flag. A single-cycle pulse marking a rising edge of the control input pin clears the protection flags. A single-cycle pulse marking an accepted serial frame clears the latched diagnosis flags. All delays are counted in system clock cycles.

Top module: `chan_fault_mgr`

## Requirements
- R1: With `chModeOvl[n]`=0 (limit mode), `ovlFlag[n]` becomes 1 at the clock edge that ends the FAULT_DLY-th consecutive cycle of `ovlDet[n]` high, and the overload never asserts `faultOff[n]`.
- R2: With `chModeOvl[n]`=1 (shutdown mode), `ovlFlag[n]` becomes 1 after OFF_DLY consecutive cycles of `ovlDet[n]` high, and `faultOff[n]` stays 1 from then on until the flag is cleared.
- R3: The overload count of a channel restarts from zero whenever `ovlDet[n]` is low for a cycle, so interrupted overloads shorter than the delay never set the flag.
- R4: `ovtDet[n]` high forces `faultOff[n]` to 1 in the same cycle, with no clock edge in between, and sets `ovtFlag[n]` at the next edge.
- R5: With `chModeOvt[n]`=0 (auto-restart), `faultOff[n]` returns to 0 as soon as `ovtDet[n]` falls. With `chModeOvt[n]`=1 (latched), `faultOff[n]` stays 1 until `ovtFlag[n]` is cleared.
- R6: An `inRise` pulse clears `ovlFlag` and `ovtFlag` of every channel at the next edge, except where the setting condition is present in that same cycle; setting wins over clearing.
- R7: `protDiag[n]` is set one edge after `ovlFlag[n]` or `ovtFlag[n]` is 1. It is cleared by a `spiAccept` pulse unless a protection flag is still 1 in that cycle.
- R8: `openDiag[n]` and `shortDiag[n]` latch their comparator only while the channel is off, meaning `gateReq[n]`=0 or `faultOff[n]`=1. A `spiAccept` pulse clears them unless the condition is still present.
- R9: Bits 2n+1:2n of `diagWord` encode channel n as 10 for a protection fault, 00 for short to ground, 01 for open load and 11 for normal, with the priority protection > short > open. The pairs of other channels are unaffected.
- R10: After reset, all flags are 0, `faultOff` is 0 while `ovtDet` is low, and `diagWord` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chModeOvl | input | NUM_CH | Overload mode per channel: 0 limit, 1 shutdown |
| chModeOvt | input | NUM_CH | Over-temperature mode per channel: 0 auto-restart, 1 latched |
| gateReq | input | NUM_CH | Gate request per channel |
| ovlDet | input | NUM_CH | Overload detected per channel |
| ovtDet | input | NUM_CH | Over-temperature detected per channel |
| openLoad | input | NUM_CH | Open-load comparator output |
| shortGnd | input | NUM_CH | Short-to-ground comparator output |
| inRise | input | 1 | One-cycle pulse on a rising edge of the input pin |
| spiAccept | input | 1 | One-cycle pulse on an accepted serial frame |
| faultOff | output | NUM_CH | Protection forces the channel off |
| ovlFlag | output | NUM_CH | Overload protection flag |
| ovtFlag | output | NUM_CH | Over-temperature protection flag |
| protDiag | output | NUM_CH | Latched protection diagnosis |
| openDiag | output | NUM_CH | Latched open-load diagnosis |
| shortDiag | output | NUM_CH | Latched short-to-ground diagnosis |
| diagWord | output | 2*NUM_CH | Packed two-bit diagnosis per channel |

## Verification
The overload input is held for every length from one cycle up to one past the delay, on every channel and in both modes. This separates an off-by-one in the counter from a wrong delay being selected, and shows whether the shutdown path is gated by the mode. Interrupted overloads separate a timer that restarts from one that only pauses. All eight combinations of protection, short and open events are applied to each channel in turn and the whole word is compared. This exposes priority errors, wrong bit positions and leakage between channels. Over-temperature is applied in both modes, with clear pulses given both while the condition is present and after it has gone, which tells auto-restart apart from latching and set-wins from clear-wins.

// File: rtl/chan_fault_mgr_pkg.sv
package chan_fault_mgr_pkg;

  typedef enum logic [1:0] {
    DIAG_SHORT = 2'b00,
    DIAG_OPEN  = 2'b01,
    DIAG_PROT  = 2'b10,
    DIAG_OK    = 2'b11
  } diagCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic protClr;
    logic diagClr;
  } clrStrobe_t;

  function automatic diagCode_e encodePair(input logic prot, input logic shortG, input logic open);
    if (prot)        return DIAG_PROT;
    else if (shortG) return DIAG_SHORT;
    else if (open)   return DIAG_OPEN;
    else             return DIAG_OK;
  endfunction

endpackage

// File: rtl/chan_fault_ctrl.sv
module chan_fault_ctrl
  import chan_fault_mgr_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int FAULT_DLY = 20000,
  parameter int OFF_DLY   = 6000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] ovlDet,
  input  logic [NUM_CH-1:0] chModeOvl,
  input  logic              inRise,
  input  logic              spiAccept,
  output logic [NUM_CH-1:0] ovlHit,
  output clrStrobe_t        strobes
);
  localparam int MAX_DLY = (FAULT_DLY > OFF_DLY) ? FAULT_DLY : OFF_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] FAULT_LAST = CNT_W'(FAULT_DLY - 1);
  localparam logic [CNT_W-1:0] OFF_LAST   = CNT_W'(OFF_DLY - 1);

  for (genvar i = 0; i < NUM_CH; i++) begin : gTimer
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lastVal;

    assign lastVal   = chModeOvl[i] ? OFF_LAST : FAULT_LAST;
    assign ovlHit[i] = ovlDet[i] && (cnt >= lastVal);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cnt <= '0;
      else if (!ovlDet[i]) cnt <= '0;
      else if (!ovlHit[i]) cnt <= cnt + CNT_W'(1);
    end
  end

  assign strobes.protClr = inRise;
  assign strobes.diagClr = spiAccept;

endmodule

// File: rtl/chan_fault_dp.sv
module chan_fault_dp
  import chan_fault_mgr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   ovlHit,
  input  clrStrobe_t          strobes,
  input  logic [NUM_CH-1:0]   chModeOvl,
  input  logic [NUM_CH-1:0]   chModeOvt,
  input  logic [NUM_CH-1:0]   gateReq,
  input  logic [NUM_CH-1:0]   ovtDet,
  input  logic [NUM_CH-1:0]   openLoad,
  input  logic [NUM_CH-1:0]   shortGnd,
  output logic [NUM_CH-1:0]   faultOff,
  output logic [NUM_CH-1:0]   ovlFlag,
  output logic [NUM_CH-1:0]   ovtFlag,
  output logic [NUM_CH-1:0]   protDiag,
  output logic [NUM_CH-1:0]   openDiag,
  output logic [NUM_CH-1:0]   shortDiag,
  output logic [2*NUM_CH-1:0] diagWord
);

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    logic chanOff;

    assign faultOff[i] = ovtDet[i] | (chModeOvt[i] & ovtFlag[i]) | (chModeOvl[i] & ovlFlag[i]);
    assign chanOff     = ~gateReq[i] | faultOff[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ovlFlag[i]   <= 1'b0;
        ovtFlag[i]   <= 1'b0;
        protDiag[i]  <= 1'b0;
        openDiag[i]  <= 1'b0;
        shortDiag[i] <= 1'b0;
      end else begin
        if (ovlHit[i])              ovlFlag[i] <= 1'b1;
        else if (strobes.protClr)   ovlFlag[i] <= 1'b0;

        if (ovtDet[i])              ovtFlag[i] <= 1'b1;
        else if (strobes.protClr)   ovtFlag[i] <= 1'b0;

        if (ovlFlag[i] | ovtFlag[i]) protDiag[i] <= 1'b1;
        else if (strobes.diagClr)    protDiag[i] <= 1'b0;

        if (openLoad[i] & chanOff)  openDiag[i] <= 1'b1;
        else if (strobes.diagClr)   openDiag[i] <= 1'b0;

        if (shortGnd[i] & chanOff)  shortDiag[i] <= 1'b1;
        else if (strobes.diagClr)   shortDiag[i] <= 1'b0;
      end
    end

    assign diagWord[2*i +: 2] = encodePair(protDiag[i], shortDiag[i], openDiag[i]);
  end

endmodule

// File: rtl/chan_fault_mgr.sv
module chan_fault_mgr
  import chan_fault_mgr_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int FAULT_DLY = 20000,
  parameter int OFF_DLY   = 6000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   chModeOvl,
  input  logic [NUM_CH-1:0]   chModeOvt,
  input  logic [NUM_CH-1:0]   gateReq,
  input  logic [NUM_CH-1:0]   ovlDet,
  input  logic [NUM_CH-1:0]   ovtDet,
  input  logic [NUM_CH-1:0]   openLoad,
  input  logic [NUM_CH-1:0]   shortGnd,
  input  logic                inRise,
  input  logic                spiAccept,
  output logic [NUM_CH-1:0]   faultOff,
  output logic [NUM_CH-1:0]   ovlFlag,
  output logic [NUM_CH-1:0]   ovtFlag,
  output logic [NUM_CH-1:0]   protDiag,
  output logic [NUM_CH-1:0]   openDiag,
  output logic [NUM_CH-1:0]   shortDiag,
  output logic [2*NUM_CH-1:0] diagWord
);
  logic [NUM_CH-1:0] ovlHit;
  clrStrobe_t        strobes;

  chan_fault_ctrl #(
    .NUM_CH(NUM_CH), .FAULT_DLY(FAULT_DLY), .OFF_DLY(OFF_DLY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ovlDet(ovlDet), .chModeOvl(chModeOvl),
    .inRise(inRise), .spiAccept(spiAccept), .ovlHit(ovlHit), .strobes(strobes)
  );

  chan_fault_dp #(.NUM_CH(NUM_CH)) uDp (
    .clk(clk), .rstN(rstN), .ovlHit(ovlHit), .strobes(strobes),
    .chModeOvl(chModeOvl), .chModeOvt(chModeOvt), .gateReq(gateReq),
    .ovtDet(ovtDet), .openLoad(openLoad), .shortGnd(shortGnd),
    .faultOff(faultOff), .ovlFlag(ovlFlag), .ovtFlag(ovtFlag),
    .protDiag(protDiag), .openDiag(openDiag), .shortDiag(shortDiag),
    .diagWord(diagWord)
  );

endmodule

// File: rtl/chan_fault_mgr_chk.sv
module chan_fault_mgr_chk #(
  parameter int NUM_CH = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CH-1:0]   gateReq,
  input logic [NUM_CH-1:0]   ovtDet,
  input logic [NUM_CH-1:0]   openLoad,
  input logic                inRise,
  input logic                spiAccept,
  input logic [NUM_CH-1:0]   faultOff,
  input logic [NUM_CH-1:0]   ovlFlag,
  input logic [NUM_CH-1:0]   ovtFlag,
  input logic [NUM_CH-1:0]   protDiag,
  input logic [NUM_CH-1:0]   openDiag,
  input logic [2*NUM_CH-1:0] diagWord
);

  // R6: protection flags only fall on a clear pulse
  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !inRise |=> (((~ovlFlag & $past(ovlFlag)) | (~ovtFlag & $past(ovtFlag))) == '0))
    else $error("a_r6_flags_sticky");

  // R6: after a clear, an over-temperature flag survives only if the condition was present
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    inRise |=> ((ovtFlag & ~$past(ovtDet)) == '0))
    else $error("a_r6_clear");

  // R7: after an accepted frame, protection diagnosis remains only where a flag was set
  a_r7_diag_clear: assert property (@(posedge clk) disable iff (!rstN)
    spiAccept |=> ((protDiag & ~$past(ovlFlag | ovtFlag)) == '0))
    else $error("a_r7_diag_clear");

  // R8: open-load diagnosis rises only for a channel that was off
  a_r8_open_when_off: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((openDiag & ~$past(openDiag) & ~($past(~gateReq | faultOff) & $past(openLoad))) == '0))
    else $error("a_r8_open_when_off");

  for (genvar i = 0; i < NUM_CH; i++) begin : gCode
    // R9: a latched protection fault always shows code 10
    a_r9_prot_code: assert property (@(posedge clk) disable iff (!rstN)
      protDiag[i] |-> (diagWord[2*i +: 2] == 2'b10))
      else $error("a_r9_prot_code");
  end

endmodule

bind chan_fault_mgr chan_fault_mgr_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .gateReq(gateReq), .ovtDet(ovtDet), .openLoad(openLoad),
  .inRise(inRise), .spiAccept(spiAccept), .faultOff(faultOff), .ovlFlag(ovlFlag),
  .ovtFlag(ovtFlag), .protDiag(protDiag), .openDiag(openDiag), .diagWord(diagWord)
);

// File: tb/tb_chan_fault_mgr.sv
`timescale 1ns/1ps
module tb_chan_fault_mgr;
  localparam int NUM_CH    = 8;
  localparam int FAULT_DLY = 5;
  localparam int OFF_DLY   = 3;
  localparam logic [2*NUM_CH-1:0] ALL_OK = '1;

  logic clk = 1'b0;
  logic rstN;
  logic [NUM_CH-1:0] chModeOvl, chModeOvt, gateReq, ovlDet, ovtDet, openLoad, shortGnd;
  logic inRise, spiAccept;
  logic [NUM_CH-1:0] faultOff, ovlFlag, ovtFlag, protDiag, openDiag, shortDiag;
  logic [2*NUM_CH-1:0] diagWord;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chan_fault_mgr #(.NUM_CH(NUM_CH), .FAULT_DLY(FAULT_DLY), .OFF_DLY(OFF_DLY)) dut (
    .clk(clk), .rstN(rstN), .chModeOvl(chModeOvl), .chModeOvt(chModeOvt),
    .gateReq(gateReq), .ovlDet(ovlDet), .ovtDet(ovtDet), .openLoad(openLoad),
    .shortGnd(shortGnd), .inRise(inRise), .spiAccept(spiAccept),
    .faultOff(faultOff), .ovlFlag(ovlFlag), .ovtFlag(ovtFlag), .protDiag(protDiag),
    .openDiag(openDiag), .shortDiag(shortDiag), .diagWord(diagWord)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRise();
    inRise = 1'b1; tick(1); inRise = 1'b0; #1;
  endtask

  task automatic pulseAccept();
    spiAccept = 1'b1; tick(1); spiAccept = 1'b0; #1;
  endtask

  initial begin
    rstN = 1'b0;
    chModeOvl = '0; chModeOvt = '0; gateReq = '0; ovlDet = '0; ovtDet = '0;
    openLoad = '0; shortGnd = '0; inRise = 1'b0; spiAccept = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1); #1;

    // R10 reset state
    chk("R10 flags", 32'(ovlFlag | ovtFlag | protDiag | openDiag | shortDiag), 32'(0));
    chk("R10 faultOff", 32'(faultOff), 32'(0));
    chk("R10 word", 32'(diagWord), 32'(ALL_OK));

    // R1 / R2: overload length sweep on every channel in both modes
    gateReq = '1;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int m = 0; m < 2; m++) begin
        int d;
        d = (m == 1) ? OFF_DLY : FAULT_DLY;
        for (int len = 1; len <= FAULT_DLY + 1; len++) begin
          logic expF;
          logic [2*NUM_CH-1:0] expW;
          string rq;
          rq = (m == 1) ? "R2" : "R1";
          expF = (len >= d);
          chModeOvl = '0; chModeOvl[c] = 1'(m);
          ovlDet[c] = 1'b1;
          tick(len);
          ovlDet[c] = 1'b0; #1;
          chk({rq, " flag"}, 32'(ovlFlag[c]), 32'(expF));
          chk({rq, " off"}, 32'(faultOff[c]), 32'(m == 1 && expF));
          tick(1); #1;
          chk({rq, " off held"}, 32'(faultOff[c]), 32'(m == 1 && expF));
          expW = ALL_OK;
          if (expF) expW[2*c +: 2] = 2'b10;
          chk("R7 R9 prot word", 32'(diagWord), 32'(expW));
          pulseRise();
          chk("R6 flag clear", 32'(ovlFlag[c]), 32'(0));
          chk("R2 off released", 32'(faultOff[c]), 32'(0));
          pulseAccept();
          chk("R7 diag clear", 32'(diagWord), 32'(ALL_OK));
        end
      end
    end

    // R3: interrupted overload never reaches the delay
    for (int m = 0; m < 2; m++) begin
      int d;
      d = (m == 1) ? OFF_DLY : FAULT_DLY;
      chModeOvl = '0; chModeOvl[2] = 1'(m);
      for (int rep = 0; rep < 3; rep++) begin
        ovlDet[2] = 1'b1; tick(d - 1);
        ovlDet[2] = 1'b0; tick(1);
      end
      #1;
      chk("R3 restart", 32'(ovlFlag[2]), 32'(0));
    end
    chModeOvl = '0;

    // R4 / R5 / R6: over-temperature in both modes
    for (int c = 0; c < NUM_CH; c++) begin
      for (int m = 0; m < 2; m++) begin
        chModeOvt = '0; chModeOvt[c] = 1'(m);
        ovtDet[c] = 1'b1; #1;
        chk("R4 immediate off", 32'(faultOff[c]), 32'(1));
        tick(1); #1;
        chk("R4 flag", 32'(ovtFlag[c]), 32'(1));
        pulseRise();
        chk("R6 set wins", 32'(ovtFlag[c]), 32'(1));
        ovtDet[c] = 1'b0; #1;
        chk("R5 restart/latch", 32'(faultOff[c]), 32'(m));
        tick(2); #1;
        chk("R5 hold", 32'(faultOff[c]), 32'(m));
        pulseRise();
        chk("R6 ovt clear", 32'(ovtFlag[c]), 32'(0));
        chk("R5 released", 32'(faultOff[c]), 32'(0));
        pulseAccept();
        chk("R7 clean", 32'(diagWord), 32'(ALL_OK));
      end
    end
    chModeOvt = '0;

    // R8: comparators ignored while on, latched while off
    for (int c = 0; c < NUM_CH; c++) begin
      gateReq = '1;
      openLoad[c] = 1'b1; shortGnd[c] = 1'b1; tick(1);
      openLoad[c] = 1'b0; shortGnd[c] = 1'b0; #1;
      chk("R8 ignored when on", 32'({openDiag[c], shortDiag[c]}), 32'(0));
      chk("R8 word when on", 32'(diagWord), 32'(ALL_OK));
      gateReq[c] = 1'b0;
      openLoad[c] = 1'b1; tick(1);
      openLoad[c] = 1'b0; #1;
      chk("R8 open latched", 32'(openDiag[c]), 32'(1));
      pulseAccept();
      chk("R8 open cleared", 32'(openDiag[c]), 32'(0));
    end

    // R9: all combinations of events on every channel
    gateReq = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int k = 0; k < 8; k++) begin
        logic p, s, o;
        logic [1:0] code;
        logic [2*NUM_CH-1:0] expW;
        p = k[2]; s = k[1]; o = k[0];
        ovtDet[c] = p; shortGnd[c] = s; openLoad[c] = o;
        tick(1);
        ovtDet[c] = 1'b0; shortGnd[c] = 1'b0; openLoad[c] = 1'b0;
        tick(1);
        pulseRise();
        code = p ? 2'b10 : (s ? 2'b00 : (o ? 2'b01 : 2'b11));
        expW = ALL_OK; expW[2*c +: 2] = code;
        chk("R9 encode", 32'(diagWord), 32'(expW));
        pulseAccept();
        chk("R8 R7 cleared", 32'(diagWord), 32'(ALL_OK));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule